// File: doc/BRIEF.md
# Isochronous Receive Sequencer

This block sits behind a packet router that has already accepted isochronous packets for the local node. Packets arrive as a stream of 32-bit quadlets. A start marker tags the header quadlet and an end marker tags the trailer quadlet. The block puts each quadlet out as 16-bit words on a data-mover port, under four strobes: sync-hit, done, read/write-valid (rw) and flag.

A configuration bit selects one of two framing modes:

- **Strip mode** (bit low): the header and trailer are shown on the bus but are not qualified by rw. Only the payload is marked valid.
- **Framed mode** (bit high): rw covers the whole packet, and flag marks the header and the trailer.

The block also compares the 4-bit sync field of the header (bits 3:0) against a programmable pattern. On a match it raises sync-hit for one cycle.

Input quadlets are taken one every two clocks. Each quadlet is held until both of its words have left. The mode bit and the pattern are captured when the header is taken.

Top module: `iso_rx_sequencer`

## Requirements
- R1: After reset, dm_data is zero, all four strobes are low and in_ready is high.
- R2: Each accepted quadlet appears as two 16-bit words on consecutive cycles, bits 31:16 first. in_ready is low in the cycle after a quadlet is loaded, so at most one quadlet is taken every two cycles.
- R3: sync-hit is high for exactly one cycle, on the first header word, when header bits 3:0 equal cfg_sync_pattern. It stays low for the whole packet otherwise.
- R4: In strip mode, done is high on the second header word only, and rw is low on both header words.
- R5: In strip mode, rw is high on every payload word and on no other word.
- R6: In strip mode, both trailer words are placed on dm_data with rw low, and flag is never high.
- R7: In framed mode, sync-hit (when matching) and done are high in the same cycle, the first header word.
- R8: In framed mode, rw is high from the first header word through the second trailer word, and low in the cycle after.
- R9: In framed mode, flag is high on exactly the two header words and the two trailer words.
- R10: The mode bit and the sync pattern are sampled when the header is loaded. Changing them while the packet is in progress does not alter that packet's output.
- R11: A quadlet offered without the start marker while no packet is open is consumed and discarded. dm_data and the strobes stay at their idle values.
- R12: When no quadlet is being output, dm_data is zero and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data-mover clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_keep_frame | input | 1 | 1 = framed mode, 0 = strip mode |
| cfg_sync_pattern | input | 4 | Sync field match pattern |
| in_valid | input | 1 | Input quadlet valid |
| in_ready | output | 1 | Block can take a quadlet this cycle |
| in_sop | input | 1 | Quadlet is the header |
| in_eop | input | 1 | Quadlet is the trailer |
| in_quad | input | 32 | Input quadlet |
| dm_data | output | 16 | Output word |
| dm_sync_hit | output | 1 | Header sync field matched |
| dm_done | output | 1 | Header boundary strobe |
| dm_rw | output | 1 | Word valid strobe |
| dm_flag | output | 1 | Header/trailer marker |

## Verification
The assertions assume well-formed packets on the input:

- every packet opens with exactly one quadlet carrying the start marker;
- it closes with one quadlet carrying the end marker;
- no quadlet carries both markers;
- in_valid is not withdrawn while a quadlet waits for in_ready.

The stimulus keeps to these rules by sending each packet as header, zero to several payload quadlets and trailer, through a task that holds each quadlet until it is taken. The only deliberate departure is a lone unmarked quadlet sent while idle, which is the discard case.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;
  typedef enum logic [1:0] {
    QK_HDR = 2'd0,
    QK_PAY = 2'd1,
    QK_TRL = 2'd2
  } qkind_t;

  typedef struct packed {
    logic sync_hit;
    logic done;
    logic rw;
    logic flag;
  } dm_strb_t;
endpackage

// File: rtl/iso_rx_sync_cmp.sv
module iso_rx_sync_cmp #(
  parameter int SYNC_W = 4
) (
  input  logic [SYNC_W-1:0] sy_field,
  input  logic [SYNC_W-1:0] pattern,
  output logic              hit
);
  assign hit = (sy_field == pattern);
endmodule

// File: rtl/iso_rx_quad_hold.sv
module iso_rx_quad_hold
  import iso_rx_pkg::*;
#(
  parameter int QUAD_W = 32,
  parameter int NWORDS = 2,
  parameter int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [QUAD_W-1:0] in_quad,
  input  logic              cfg_keep,
  input  logic              sync_match,
  output logic              in_ready,
  output logic              busy,
  output logic [IDX_W-1:0]  idx,
  output logic [QUAD_W-1:0] quad,
  output qkind_t            kind,
  output logic              keep_l,
  output logic              match_l
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

  logic in_pkt;
  logic last_word;
  logic take;
  logic load;

  assign last_word = (idx == LAST_IDX);
  assign in_ready  = !busy || last_word;
  assign take      = in_valid && in_ready;
  assign load      = take && (in_sop || in_pkt);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      idx     <= '0;
      in_pkt  <= 1'b0;
      quad    <= '0;
      kind    <= QK_PAY;
      keep_l  <= 1'b0;
      match_l <= 1'b0;
    end else if (load) begin
      busy   <= 1'b1;
      idx    <= '0;
      quad   <= in_quad;
      in_pkt <= !in_eop;
      kind   <= in_sop ? QK_HDR : (in_eop ? QK_TRL : QK_PAY);
      if (in_sop) begin
        keep_l  <= cfg_keep;
        match_l <= sync_match;
      end
    end else if (busy) begin
      if (last_word) busy <= 1'b0;
      else           idx  <= idx + 1'b1;
    end
  end

  AST_READY_GAP: assert property (@(posedge clk) disable iff (rst)
    load |=> !in_ready) else $error("ready gap"); // R2

  AST_IDX_RESTART: assert property (@(posedge clk) disable iff (rst)
    load |=> (busy && idx == '0)) else $error("word index restart"); // R2
endmodule

// File: rtl/iso_rx_strobe_gen.sv
module iso_rx_strobe_gen
  import iso_rx_pkg::*;
#(
  parameter int QUAD_W = 32,
  parameter int WORD_W = 16,
  parameter int NWORDS = 2,
  parameter int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic [IDX_W-1:0]  idx,
  input  logic [QUAD_W-1:0] quad,
  input  qkind_t            kind,
  input  logic              keep_l,
  input  logic              match_l,
  output logic [WORD_W-1:0] dm_data,
  output dm_strb_t          dm_strb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

  logic [WORD_W-1:0] words [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_split
    assign words[g] = quad[QUAD_W-1-g*WORD_W -: WORD_W];
  end

  logic [WORD_W-1:0] nxt_data;
  dm_strb_t          nxt_strb;
  logic              first_w;
  logic              last_w;

  assign first_w = (idx == '0);
  assign last_w  = (idx == LAST_IDX);

  always_comb begin
    nxt_data = '0;
    nxt_strb = '0;
    if (busy) begin
      nxt_data = words[idx];
      unique case (kind)
        QK_HDR: begin
          nxt_strb.sync_hit = first_w && match_l;
          nxt_strb.done     = keep_l ? first_w : last_w;
          nxt_strb.rw       = keep_l;
          nxt_strb.flag     = keep_l;
        end
        QK_PAY: nxt_strb.rw = 1'b1;
        QK_TRL: begin
          nxt_strb.rw   = keep_l;
          nxt_strb.flag = keep_l;
        end
        default: nxt_strb = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dm_data <= '0;
      dm_strb <= '0;
    end else begin
      dm_data <= nxt_data;
      dm_strb <= nxt_strb;
    end
  end

  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    dm_strb.sync_hit |=> !dm_strb.sync_hit) else $error("sync pulse width"); // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    dm_strb.done |=> !dm_strb.done) else $error("done pulse width"); // R7

  AST_FLAG_UNDER_RW: assert property (@(posedge clk) disable iff (rst)
    dm_strb.flag |-> dm_strb.rw) else $error("flag outside rw"); // R9

  AST_STRIP_SYNC_BEFORE_DONE: assert property (@(posedge clk) disable iff (rst)
    (dm_strb.sync_hit && !dm_strb.rw) |=> dm_strb.done) else $error("strip done order"); // R4
endmodule

// File: rtl/iso_rx_sequencer.sv
module iso_rx_sequencer
  import iso_rx_pkg::*;
#(
  parameter int QUAD_W = 32,
  parameter int WORD_W = 16,
  parameter int SYNC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_keep_frame,
  input  logic [SYNC_W-1:0] cfg_sync_pattern,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [QUAD_W-1:0] in_quad,
  output logic [WORD_W-1:0] dm_data,
  output logic              dm_sync_hit,
  output logic              dm_done,
  output logic              dm_rw,
  output logic              dm_flag
);
  localparam int NWORDS = QUAD_W / WORD_W;
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic              sync_match;
  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic [QUAD_W-1:0] quad;
  qkind_t            kind;
  logic              keep_l;
  logic              match_l;
  dm_strb_t          strb;

  iso_rx_sync_cmp #(.SYNC_W(SYNC_W)) u_cmp (
    .sy_field (in_quad[SYNC_W-1:0]),
    .pattern  (cfg_sync_pattern),
    .hit      (sync_match)
  );

  iso_rx_quad_hold #(.QUAD_W(QUAD_W), .NWORDS(NWORDS), .IDX_W(IDX_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sop     (in_sop),
    .in_eop     (in_eop),
    .in_quad    (in_quad),
    .cfg_keep   (cfg_keep_frame),
    .sync_match (sync_match),
    .in_ready   (in_ready),
    .busy       (busy),
    .idx        (idx),
    .quad       (quad),
    .kind       (kind),
    .keep_l     (keep_l),
    .match_l    (match_l)
  );

  iso_rx_strobe_gen #(.QUAD_W(QUAD_W), .WORD_W(WORD_W), .NWORDS(NWORDS), .IDX_W(IDX_W)) u_strb (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .idx     (idx),
    .quad    (quad),
    .kind    (kind),
    .keep_l  (keep_l),
    .match_l (match_l),
    .dm_data (dm_data),
    .dm_strb (strb)
  );

  assign dm_sync_hit = strb.sync_hit;
  assign dm_done     = strb.done;
  assign dm_rw       = strb.rw;
  assign dm_flag     = strb.flag;
endmodule

// File: tb/test_iso_rx_sequencer.sv
`timescale 1ns/1ps
module test_iso_rx_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_keep_frame = 1'b0;
  logic [3:0]  cfg_sync_pattern = 4'h0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sop = 1'b0;
  logic        in_eop = 1'b0;
  logic [31:0] in_quad = '0;
  logic [15:0] dm_data;
  logic        dm_sync_hit, dm_done, dm_rw, dm_flag;

  always #2.5 clk = ~clk;

  iso_rx_sequencer i_iso_rx_sequencer (
    .clk(clk), .rst(rst), .cfg_keep_frame(cfg_keep_frame),
    .cfg_sync_pattern(cfg_sync_pattern), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_quad(in_quad), .dm_data(dm_data),
    .dm_sync_hit(dm_sync_hit), .dm_done(dm_done), .dm_rw(dm_rw), .dm_flag(dm_flag)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [19:0] exp_w [0:63];
  int          n_exp;
  logic [31:0] quads [0:31];

  function automatic logic [19:0] actual_w();
    return {dm_data, dm_sync_hit, dm_done, dm_rw, dm_flag};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Offer one quadlet and hold it until taken; optionally check the gap after a load.
  task automatic push(input logic [31:0] q, input bit sop, input bit eop, input bit loads);
    @(negedge clk);
    in_valid = 1'b1; in_quad = q; in_sop = sop; in_eop = eop;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    if (loads) chk(in_ready == 1'b0, "R2 ready gap", {31'd0, in_ready}, 32'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(actual_w() == 20'd0, "R1 idle outputs", {12'd0, actual_w()}, 32'd0);
    chk(in_ready == 1'b1, "R1 ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic run_pkt(input bit keep, input logic [3:0] pat, input logic [31:0] hdr,
                         input int npay, input bit flip, input string req);
    bit m;
    int nq;
    m  = (hdr[3:0] == pat);
    nq = npay + 2;
    quads[0] = hdr;
    for (int k = 0; k < npay; k++) quads[k+1] = 32'hA100_0010 + k * 32'h0103_0105;
    quads[nq-1] = 32'hC0DE_7700 ^ npay;
    n_exp = 0;
    for (int i = 0; i < nq; i++) begin
      for (int h = 0; h < 2; h++) begin
        logic [15:0] d;
        bit s, dn, rw, fl;
        d = (h == 0) ? quads[i][31:16] : quads[i][15:0];
        s = 0; dn = 0; rw = 0; fl = 0;
        if (i == 0) begin
          s  = (h == 0) && m;
          dn = keep ? (h == 0) : (h == 1);
          rw = keep; fl = keep;
        end else if (i == nq - 1) begin
          rw = keep; fl = keep;
        end else begin
          rw = 1;
        end
        exp_w[n_exp] = {d, s, dn, rw, fl};
        n_exp++;
      end
    end
    @(negedge clk);
    cfg_keep_frame = keep; cfg_sync_pattern = pat;
    fork
      begin
        for (int i = 0; i < nq; i++) begin
          push(quads[i], i == 0, i == nq - 1, 1'b1);
          if (flip && i == 0) begin
            cfg_keep_frame = !keep;
            cfg_sync_pattern = ~pat;
          end
        end
      end
      begin
        int guard;
        guard = 0;
        @(negedge clk);
        while (actual_w() == 20'd0 && guard < 40) begin
          @(negedge clk);
          guard++;
        end
        for (int c = 0; c < n_exp; c++) begin
          chk(actual_w() == exp_w[c], req, {12'd0, actual_w()}, {12'd0, exp_w[c]});
          @(negedge clk);
        end
        // R8 R12: rw drops and the port goes idle after the last trailer word
        chk(actual_w() == 20'd0, "R8 R12 idle after packet", {12'd0, actual_w()}, 32'd0);
      end
    join
    cfg_keep_frame = 1'b0; cfg_sync_pattern = 4'h0;
  endtask

  task automatic t_drop();
    push(32'h5A5A_1234, 1'b0, 1'b0, 1'b0);
    for (int c = 0; c < 4; c++) begin
      chk(actual_w() == 20'd0, "R11 discarded quadlet", {12'd0, actual_w()}, 32'd0);
      chk(in_ready == 1'b1, "R11 ready stays", {31'd0, in_ready}, 32'd1);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    run_pkt(1'b0, 4'h6, 32'h1234_5676, 3, 1'b0, "R2 R3 R4 R5 R6 strip match");
    run_pkt(1'b0, 4'h3, 32'h2222_0009, 2, 1'b0, "R3 R4 R5 strip nomatch");
    run_pkt(1'b1, 4'hB, 32'h4D00_00AB, 3, 1'b0, "R2 R3 R7 R8 R9 framed match");
    run_pkt(1'b1, 4'h1, 32'h8001_FFF0, 1, 1'b0, "R3 R7 R8 R9 framed nomatch");
    run_pkt(1'b0, 4'hF, 32'h7700_000F, 0, 1'b0, "R4 R6 strip empty");
    run_pkt(1'b1, 4'h2, 32'h0F0F_0002, 0, 1'b0, "R8 R9 framed empty");
    run_pkt(1'b1, 4'h5, 32'h3300_0035, 2, 1'b1, "R10 framed flip");
    run_pkt(1'b0, 4'hA, 32'h6100_001A, 2, 1'b1, "R10 strip flip");
    t_drop();
    run_pkt(1'b1, 4'h4, 32'h9999_0004, 1, 1'b0, "R11 packet after discard");
    repeat (4) @(negedge clk);
    chk(actual_w() == 20'd0, "R12 idle", {12'd0, actual_w()}, 32'd0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule